// File: doc/BRIEF.md
# Triple-Redundant Configuration Scrubber

This controller keeps three redundant reprogrammable devices consistent. On a start pulse it pulls the three configuration readback streams in lockstep, one byte from each device per transfer. At every byte position it looks for a device whose byte differs from both of the other two, and it keeps a sticky per-device miscompare flag for the whole pass. Once the last byte has been taken, the flags become the reload mask.

If no device has been flagged, the pass ends at once and the stored image is never read. If one or more devices have been flagged, the controller clears those devices only. It then streams the stored non-volatile image into them, byte by byte and in address order. At the end it raises a sync-request pulse so that the reloaded devices rejoin the others at the next system synchronisation. The pass is meant to be started again at a regular interval. A device that picked up a bad load is therefore caught and reloaded on a later pass.

The controller reaches the devices and the image memory only through simple byte handshakes. The port protocols behind them lie outside this block.

Top module: `cfg_scrubber`

## Requirements
- R1: `rb_ready` is high only during the readback phase of a pass. Exactly `CFG_BYTES` transfers (cycles with `rb_valid` and `rb_ready` both high) are taken before the pass is evaluated. Device d's byte is carried on `rb_data[8d+7:8d]`.
- R2: A device is flagged when its byte differs from the bytes of both other devices at any one position. If all three bytes differ at a position, all three devices are flagged. `reload_mask` (bit d = device d) is updated only after the final byte and holds its value until the next evaluation.
- R3: If no device is flagged, `done` pulses two cycles after the final byte is accepted, and `reload_mask` reads 0. In that pass `img_rd`, `clr_req` and `sync_req` stay low.
- R4: When exactly one device is flagged, `clr_req` carries only that device's bit until `clr_ack`, and `ld_mask` names only that device during the load.
- R5: When several devices are flagged, `clr_req` and `ld_mask` carry every flagged device together, as a full re-initialisation.
- R6: The reload reads image addresses 0 to `CFG_BYTES-1` in order, one `img_rd` request per byte. Each byte returned on `img_data` with `img_vld` is presented on `ld_data` with `ld_valid`, and it is held steady until `ld_ready`.
- R7: `sync_req` pulses for one cycle together with `done`, but only at the end of a pass that reloaded at least one device.
- R8: A start pulse that arrives while a pass is in progress is ignored. It does not shorten, restart or lengthen the pass.
- R9: `busy` is high from the cycle after an accepted start until the pass finishes, and it is low in the cycle in which `done` is high.
- R10: The miscompare flags are cleared at every accepted start, so a device flagged on an earlier pass is not reloaded if it compares clean now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scrub pass (taken only when idle) |
| rb_valid | input | 1 | All three readback bytes are present |
| rb_data | input | 3*W | Readback bytes, device d in bits [W*d+W-1:W*d] |
| rb_ready | output | 1 | Controller accepts readback bytes |
| clr_req | output | 3 | Clear request per device |
| clr_ack | input | 1 | Requested clears are complete |
| img_rd | output | 1 | Image byte request |
| img_addr | output | AW | Image byte address |
| img_vld | input | 1 | Requested image byte is on img_data |
| img_data | input | W | Image byte |
| ld_valid | output | 1 | Load byte is valid |
| ld_data | output | W | Load byte |
| ld_mask | output | 3 | Devices that receive the load byte |
| ld_ready | input | 1 | Load byte accepted |
| busy | output | 1 | Pass in progress |
| reload_mask | output | 3 | Devices flagged by the last evaluation |
| done | output | 1 | One-cycle pulse at the end of a pass |
| sync_req | output | 1 | One-cycle resynchronisation request after a reload |

## Verification
The bench builds the controller with `CFG_BYTES` = 6 and `W` = 8, so every pass is only a few dozen cycles long. With streams this short, a single run can place faults at the first byte, the last byte and positions between them. It can also chain several passes to show that the flags clear between passes. The short image also lets the bench check every load address and byte one by one, including a stalled load handshake and a stall on the readback side.

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int CFG_BYTES = 4096,
  parameter int W = 8,
  localparam int AW = (CFG_BYTES > 2) ? $clog2(CFG_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           rb_valid,
  input  logic [3*W-1:0] rb_data,
  output logic           rb_ready,
  output logic [2:0]     clr_req,
  input  logic           clr_ack,
  output logic           img_rd,
  output logic [AW-1:0]  img_addr,
  input  logic           img_vld,
  input  logic [W-1:0]   img_data,
  output logic           ld_valid,
  output logic [W-1:0]   ld_data,
  output logic [2:0]     ld_mask,
  input  logic           ld_ready,
  output logic           busy,
  output logic [2:0]     reload_mask,
  output logic           done,
  output logic           sync_req
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_EVAL, S_CLEAR, S_FETCH, S_PUSH} st_t;

  localparam logic [AW-1:0] LAST = AW'(CFG_BYTES - 1);

  st_t           st;
  logic [AW-1:0] cnt;
  logic [2:0]    flags;

  wire [W-1:0] b0 = rb_data[W-1:0];
  wire [W-1:0] b1 = rb_data[2*W-1:W];
  wire [W-1:0] b2 = rb_data[3*W-1:2*W];

  wire [2:0] odd = {(b2 != b0) && (b2 != b1),
                    (b1 != b0) && (b1 != b2),
                    (b0 != b1) && (b0 != b2)};

  wire rb_take = (st == S_READ) && rb_valid;
  wire at_last = (cnt == LAST);

  assign rb_ready = (st == S_READ);
  assign clr_req  = (st == S_CLEAR) ? reload_mask : 3'b000;
  assign img_rd   = (st == S_FETCH);
  assign img_addr = cnt;
  assign ld_valid = (st == S_PUSH);
  assign ld_mask  = reload_mask;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      flags       <= 3'b000;
      reload_mask <= 3'b000;
      ld_data     <= '0;
      done        <= 1'b0;
      sync_req    <= 1'b0;
    end else begin
      done     <= 1'b0;
      sync_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          flags <= 3'b000;
          cnt   <= '0;
          st    <= S_READ;
        end
        S_READ: if (rb_take) begin
          flags <= flags | odd;
          if (at_last) begin
            cnt <= '0;
            st  <= S_EVAL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_EVAL: begin
          reload_mask <= flags;
          cnt         <= '0;
          if (flags == 3'b000) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_CLEAR;
          end
        end
        S_CLEAR: if (clr_ack) st <= S_FETCH;
        S_FETCH: if (img_vld) begin
          ld_data <= img_data;
          st      <= S_PUSH;
        end
        S_PUSH: if (ld_ready) begin
          if (at_last) begin
            cnt      <= '0;
            done     <= 1'b1;
            sync_req <= 1'b1;
            st       <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            st  <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_scrubber_chk.sv
module cfg_scrubber_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rb_ready,
  input logic [2:0]   clr_req,
  input logic         img_rd,
  input logic         ld_valid,
  input logic         ld_ready,
  input logic [W-1:0] ld_data,
  input logic [2:0]   ld_mask,
  input logic         busy,
  input logic [2:0]   reload_mask,
  input logic         done,
  input logic         sync_req
);

  AST_RB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ready |-> busy) else $error("rb_ready outside pass"); // R1

  AST_MASK_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rb_ready |=> $stable(reload_mask)) else $error("mask moved during readback"); // R2

  AST_NO_IMG_IF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    img_rd |-> (reload_mask != 3'b000)) else $error("image read with empty mask"); // R3

  AST_CLR_ONLY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req != 3'b000) |-> (clr_req == reload_mask)) else $error("clear of unflagged device"); // R4

  AST_LOAD_TARGETS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (ld_mask == reload_mask && ld_mask != 3'b000)) else $error("load mask wrong"); // R5

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> (ld_valid && $stable(ld_data))) else $error("load byte dropped"); // R6

  AST_SYNC_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> (done && reload_mask != 3'b000)) else $error("sync without reload"); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R9

endmodule

bind cfg_scrubber cfg_scrubber_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rb_ready(rb_ready), .clr_req(clr_req),
  .img_rd(img_rd), .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
  .ld_mask(ld_mask), .busy(busy), .reload_mask(reload_mask), .done(done),
  .sync_req(sync_req)
);

// File: tb/cfg_scrubber_bench.sv
`timescale 1ns/1ps
module cfg_scrubber_bench;
  localparam int N  = 6;
  localparam int W  = 8;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rb_valid = 1'b0, clr_ack = 1'b0, img_vld = 1'b0, ld_ready = 1'b0;
  logic [3*W-1:0] rb_data = '0;
  logic [W-1:0]   img_data = '0;
  logic rb_ready, img_rd, ld_valid, busy, done, sync_req;
  logic [2:0] clr_req, ld_mask, reload_mask;
  logic [AW-1:0] img_addr;
  logic [W-1:0] ld_data;

  int n_chk = 0, n_bad = 0, img_cnt = 0, clr_cnt = 0, sync_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_scrubber #(.CFG_BYTES(N), .W(W)) u_cfg_scrubber (
    .clk(clk), .rst_n(rst_n), .start(start), .rb_valid(rb_valid), .rb_data(rb_data),
    .rb_ready(rb_ready), .clr_req(clr_req), .clr_ack(clr_ack), .img_rd(img_rd),
    .img_addr(img_addr), .img_vld(img_vld), .img_data(img_data), .ld_valid(ld_valid),
    .ld_data(ld_data), .ld_mask(ld_mask), .ld_ready(ld_ready), .busy(busy),
    .reload_mask(reload_mask), .done(done), .sync_req(sync_req)
  );

  always @(posedge clk) begin
    if (img_rd) img_cnt++;
    if (clr_req != 3'b000) clr_cnt++;
    if (sync_req) sync_cnt++;
  end

  function automatic logic [W-1:0] img(input int k);
    return W'(k * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pass(input logic [2:0] ma, input int pa, input logic [2:0] mb,
                          input int pb, input logic [2:0] exp, input bit poke);
    int img0 = img_cnt, clr0 = clr_cnt, sync0 = sync_cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    for (int k = 0; k < N; k++) begin
      if (k == 2) begin
        rb_valid = 1'b0;
        @(negedge clk);
        chk(rb_ready == 1'b1, "R1 ready held over stall", rb_ready, 1);
      end
      rb_valid = 1'b1;
      for (int d = 0; d < 3; d++) begin
        logic [W-1:0] v;
        v = img(k);
        if (ma[d] && k == pa) v = v ^ W'(d + 1);
        if (mb[d] && k == pb) v = v ^ W'(d + 1);
        rb_data[W*d +: W] = v;
      end
      start = (poke && k == 1);
      @(negedge clk);
    end
    rb_valid = 1'b0;
    start = 1'b0;
    chk(rb_ready == 1'b0, "R1 readback closed after N bytes", rb_ready, 0);
    @(negedge clk);
    if (exp == 3'b000) begin
      chk(done == 1'b1, "R3 done on clean pass", done, 1);
      chk(reload_mask == 3'b000, "R3 clean mask", reload_mask, 0);
      chk(img_cnt == img0 && clr_cnt == clr0, "R3 no image or clear", img_cnt - img0, 0);
      chk(sync_cnt == sync0, "R7 no sync on clean pass", sync_cnt - sync0, 0);
      chk(busy == 1'b0, "R9 idle with done", busy, 0);
      if (poke) chk(done == 1'b1, "R8 start while busy ignored", done, 1);
    end else begin
      chk(reload_mask == exp, "R2 flagged devices", reload_mask, exp);
      chk(clr_req == exp, ($countones(exp) == 1) ? "R4 single clear" : "R5 multi clear",
          clr_req, exp);
      clr_ack = 1'b1;
      @(negedge clk) clr_ack = 1'b0;
      for (int k = 0; k < N; k++) begin
        chk(img_rd == 1'b1 && img_addr == AW'(k), "R6 image address order", img_addr, k);
        img_vld = 1'b1;
        img_data = img(k);
        @(negedge clk) img_vld = 1'b0;
        chk(ld_valid == 1'b1 && ld_data == img(k), "R6 load byte", ld_data, img(k));
        chk(ld_mask == exp, ($countones(exp) == 1) ? "R4 load target" : "R5 load targets",
            ld_mask, exp);
        if (k == 1) begin
          @(negedge clk);
          chk(ld_valid == 1'b1 && ld_data == img(k), "R6 load held in stall", ld_data, img(k));
        end
        ld_ready = 1'b1;
        @(negedge clk) ld_ready = 1'b0;
      end
      chk(done == 1'b1 && sync_req == 1'b1, "R7 sync with done", sync_req, 1);
      chk(busy == 1'b0, "R9 idle at end", busy, 0);
    end
    @(negedge clk);
    chk(done == 1'b0 && sync_req == 1'b0, "R7 single-cycle pulses", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rb_ready == 1'b0 && done == 1'b0, "R1 reset idle", busy, 0);
    chk(reload_mask == 3'b000 && clr_req == 3'b000, "R9 reset outputs", reload_mask, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_pass(3'b000, 0, 3'b000, 0, 3'b000, 1'b0);
    run_pass(3'b010, 3, 3'b000, 0, 3'b010, 1'b0);
    run_pass(3'b001, 0, 3'b100, N - 1, 3'b101, 1'b0);
    run_pass(3'b011, 2, 3'b000, 0, 3'b111, 1'b0);
    run_pass(3'b111, N - 1, 3'b000, 0, 3'b111, 1'b1);
    run_pass(3'b000, 0, 3'b000, 0, 3'b000, 1'b1); // R10 flags cleared, R8 start ignored
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule